// File: doc/BRIEF.md
# Walking-One Boundary Pin-Map Verifier

This block checks that every device pin is wired to the boundary-register cell a test program expects. It drives a JTAG target as the master, using TCK, TMS and TDI and reading back TDO. It also drives the target's input pins and observes its output pins.

In the input pass it loads the sampling instruction. It then raises one input pin at a time and captures the pin states. For each pin it shifts the whole boundary register out and requires the single one to appear at that pin's table position. In the output pass it loads the external-test instruction and shifts in a register image whose only one sits in the pin's cell. After the update it requires exactly that pin to go high among the output pins.

Every scan is followed by eight fill bits, so a register that is longer or shorter than declared is caught. Each scan costs about one register length of shifts, and there is one scan per pin, so a full run is roughly quadratic in the pin count. The run halts at the first mismatch and holds the failing pin and the observed position until the next start.

Top module: `walk1_pinmap_verifier`

## Requirements
- R1: While reset is held, and afterwards until a start pulse, `tck` is low, `busy`, `done` and `fail` are 0, `err_code` is 0, and `pin_drv_en` is all zero.
- R2: A run starts with six TCK bits that take the target TAP to Run-Test/Idle: five with TMS high, then one with TMS low. It then loads the instruction register, least significant bit first. The input pass uses `OP_SAMPLE` (default 4'b0010) and the output pass uses `OP_EXTEST` (default 4'b0000). Every data capture of the input pass happens under the first opcode, and every data capture of the output pass under the second.
- R3: The input pass visits the pins set in `in_mask` in ascending index order. During a pin's scan, `pin_drv` is one-hot on that pin and `pin_drv_en` equals `in_mask`. Each visit is one data scan of `BSL+FILL` shift bits.
- R4: In the input pass, the first `BSL` bits shifted out form the captured window, and out-bit position 0 is the first bit seen on TDO. The window must hold exactly one 1, at position `exp_tab[p*CW +: CW]`. Otherwise the run fails with `err_code`=1, `err_pin`=p, and `err_obs` set to the first set position other than the expected one, or all ones if there is none.
- R5: The first `FILL` TDI bits of every scan are 1. Out-bit positions `BSL` to `BSL+FILL-1` must all read 1. Otherwise the run fails with `err_code`=3 and `err_obs` all ones. This check takes priority over R4 and R6.
- R6: The output pass visits the pins set in `out_mask` in ascending order. It shifts so that only cell `exp_tab` of pin p holds 1 after the update, and releases `pin_drv_en`. `pin_obs & out_mask` must then equal a one-hot on p. Otherwise the run fails with `err_code`=2, `err_pin`=p, and `err_obs` set to the lowest other high pin index, or all ones if there is none.
- R7: At the first mismatch the run stops with `done`=1 and `fail`=1. All results hold without change until the next `start`, and a new start runs again without a reset.
- R8: A run with no mismatch ends with `done`=1, `fail`=0 and `err_code`=0.
- R9: A pin set in both masks is tested in both passes. A pin set in neither mask costs no scan. Empty masks give a passing run of only the TAP reset and the two instruction loads.
- R10: Each TCK bit lasts two clock cycles. TMS and TDI change only while `tck` is low. A passing run takes 6 + 2(IRW+6) + S(BSL+FILL+5) TCK rising edges, where S is the number of pin scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle or done |
| in_mask | input | NPIN | Pins tested in the input pass |
| out_mask | input | NPIN | Pins tested in the output pass |
| exp_tab | input | NPIN*CW | Expected cell index per pin, pin 0 in the low field |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Serial data to the target |
| tdo | input | 1 | Serial data from the target |
| pin_drv | output | NPIN | Values driven onto target input pins |
| pin_drv_en | output | NPIN | Drive enable per target pin |
| pin_obs | input | NPIN | Observed target pin levels |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Run finished on a mismatch |
| err_code | output | 2 | 0 none, 1 input map, 2 output map, 3 length |
| err_pin | output | PW | Pin under test at the mismatch |
| err_obs | output | CW | Observed position, or all ones |

## Verification
The assertions take for granted the following about the inputs:
- `start` is pulsed only while the block is idle or done.
- The masks and the expected table stay constant for the whole run.
- TDO changes only on falling TCK, as a compliant target does.
- Every `exp_tab` entry is below `BSL`.

The bench keeps within these assumptions. It changes masks, the table and its target model only between runs, and it pulses `start` for one cycle on a falling clock edge. Its target model updates TDO on the falling test-clock edge and acts on TMS and TDI at the rising edge.

// File: rtl/walk1_pinmap_verifier.sv
module walk1_pinmap_verifier #(
  parameter int NPIN = 6,
  parameter int BSL  = 10,
  parameter int FILL = 8,
  parameter int IRW  = 4,
  parameter logic [IRW-1:0] OP_SAMPLE = IRW'(2),
  parameter logic [IRW-1:0] OP_EXTEST = IRW'(0)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic [NPIN-1:0] in_mask,
  input  logic [NPIN-1:0] out_mask,
  input  logic [NPIN*$clog2(BSL+1)-1:0] exp_tab,
  output logic tck,
  output logic tms,
  output logic tdi,
  input  logic tdo,
  output logic [NPIN-1:0] pin_drv,
  output logic [NPIN-1:0] pin_drv_en,
  input  logic [NPIN-1:0] pin_obs,
  output logic busy,
  output logic done,
  output logic fail,
  output logic [1:0] err_code,
  output logic [$clog2(NPIN+1)-1:0] err_pin,
  output logic [$clog2(BSL+1)-1:0] err_obs
);
  localparam int CW  = $clog2(BSL+1);
  localparam int PW  = $clog2(NPIN+1);
  localparam int SW  = BSL + FILL;
  localparam int CNW = $clog2(((SW > IRW) ? SW : IRW) + 8);
  localparam logic [CW-1:0] NONE = '1;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_IRH, S_IRS, S_IRT, S_SEL, S_DRH, S_DRS, S_DRT, S_CHK, S_DONE
  } st_t;

  st_t state, nxt;
  logic [CNW-1:0] cnt, last;
  logic [PW-1:0] pidx;
  logic opass, seen, bad, lenbad;
  logic [CW-1:0] bad_idx, cur_exp, low_bad;
  logic [NPIN-1:0] pin_hot, act_sh, out_seen, out_bad;
  logic [IRW-1:0] opc_sh;
  logic stepping, out_miss;

  assign stepping = state inside {S_RST, S_IRH, S_IRS, S_IRT, S_DRH, S_DRS, S_DRT};
  assign busy     = state != S_IDLE && state != S_DONE;
  assign done     = state == S_DONE;
  assign pin_hot  = NPIN'(1) << pidx;
  assign act_sh   = (opass ? out_mask : in_mask) >> pidx;
  assign pin_drv    = (busy && !opass) ? pin_hot : '0;
  assign pin_drv_en = (busy && !opass) ? in_mask : '0;
  assign out_seen = pin_obs & out_mask;
  assign out_bad  = out_seen & ~pin_hot;
  assign out_miss = ~|(out_seen & pin_hot);
  assign opc_sh   = (opass ? OP_EXTEST : OP_SAMPLE) >> cnt;

  always_comb begin
    int pi;
    pi = (int'(pidx) < NPIN) ? int'(pidx) : 0;
    cur_exp = exp_tab[pi*CW +: CW];
    low_bad = NONE;
    for (int i = NPIN-1; i >= 0; i--)
      if (out_bad[i]) low_bad = CW'(i);
  end

  always_comb begin
    last = '0;
    nxt  = state;
    case (state)
      S_RST: begin last = CNW'(5);     nxt = S_IRH; end
      S_IRH: begin last = CNW'(3);     nxt = S_IRS; end
      S_IRS: begin last = CNW'(IRW-1); nxt = S_IRT; end
      S_IRT: begin last = CNW'(1);     nxt = S_SEL; end
      S_DRH: begin last = CNW'(2);     nxt = S_DRS; end
      S_DRS: begin last = CNW'(SW-1);  nxt = S_DRT; end
      S_DRT: begin last = CNW'(1);     nxt = S_CHK; end
      default: ;
    endcase
  end

  always_comb begin
    tms = 1'b0;
    tdi = 1'b0;
    case (state)
      S_RST: tms = cnt < CNW'(5);
      S_IRH: tms = cnt < CNW'(2);
      S_IRS: begin
        tms = cnt == CNW'(IRW-1);
        tdi = opc_sh[0];
      end
      S_IRT, S_DRT, S_DRH: tms = cnt == '0;
      S_DRS: begin
        tms = cnt == CNW'(SW-1);
        tdi = (cnt < CNW'(FILL)) ? 1'b1
              : (opass && (cnt - CNW'(FILL) == CNW'(cur_exp)));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; tck <= 1'b0; pidx <= '0; opass <= 1'b0;
      seen <= 1'b0; bad <= 1'b0; lenbad <= 1'b0; bad_idx <= '0;
      fail <= 1'b0; err_code <= '0; err_pin <= '0; err_obs <= '0;
    end else if ((state == S_IDLE || state == S_DONE) && start) begin
      state <= S_RST; cnt <= '0; tck <= 1'b0; pidx <= '0; opass <= 1'b0;
      fail <= 1'b0; err_code <= '0; err_pin <= '0; err_obs <= '0;
    end else if (stepping) begin
      if (!tck) begin
        tck <= 1'b1;
        if (state == S_DRS) begin
          if (cnt < CNW'(BSL)) begin
            if (tdo && !opass) begin
              if (cnt == CNW'(cur_exp)) seen <= 1'b1;
              else if (!bad) begin
                bad <= 1'b1;
                bad_idx <= CW'(cnt);
              end
            end
          end else if (!tdo) lenbad <= 1'b1;
        end
      end else begin
        tck <= 1'b0;
        if (cnt == last) begin
          cnt <= '0;
          state <= nxt;
        end else cnt <= cnt + 1'b1;
      end
    end else if (state == S_SEL) begin
      if (int'(pidx) >= NPIN) begin
        pidx <= '0;
        if (!opass) begin
          opass <= 1'b1;
          state <= S_IRH;
        end else state <= S_DONE;
      end else if (act_sh[0]) begin
        seen <= 1'b0; bad <= 1'b0; lenbad <= 1'b0; bad_idx <= '0;
        state <= S_DRH;
      end else pidx <= pidx + 1'b1;
    end else if (state == S_CHK) begin
      if (lenbad) begin
        fail <= 1'b1; err_code <= 2'd3; err_pin <= pidx; err_obs <= NONE; state <= S_DONE;
      end else if (!opass && (bad || !seen)) begin
        fail <= 1'b1; err_code <= 2'd1; err_pin <= pidx;
        err_obs <= bad ? bad_idx : NONE; state <= S_DONE;
      end else if (opass && ((|out_bad) || out_miss)) begin
        fail <= 1'b1; err_code <= 2'd2; err_pin <= pidx; err_obs <= low_bad; state <= S_DONE;
      end else begin
        pidx <= pidx + 1'b1;
        state <= S_SEL;
      end
    end
  end

  a_r1_tck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
  a_r3_single_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pin_drv));
  a_r3_drive_held_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DRS) |-> $stable(pin_drv));
  a_r10_change_only_low: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi)));
  a_r7_fail_is_final: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
  a_r7_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(err_code) && $stable(err_pin) && $stable(err_obs) && $stable(fail)));
  a_r4_fail_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (err_code != 2'd0));
  a_r8_pass_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (err_code == 2'd0));
endmodule

// File: tb/test_walk1_pinmap_verifier.sv
module test_walk1_pinmap_verifier;
  localparam int PERIOD = 10;
  localparam int NP = 6;
  localparam int NV = 9;
  localparam logic [3:0] SAM = 4'b0010;
  localparam logic [3:0] EXT = 4'b0000;

  // vector table: in mask, out mask, model variant, model length, code, pin, obs
  localparam int V_IN [NV] = '{15, 15, 15, 15, 15, 15, 15,  0,  1};
  localparam int V_OUT[NV] = '{60, 60, 60, 60, 60, 60, 60,  0, 60};
  localparam int V_VAR[NV] = '{ 0,  1,  2,  0,  0,  3,  4,  0,  1};
  localparam int V_LEN[NV] = '{10, 10, 10, 11,  9, 10, 10, 10, 10};
  localparam int V_COD[NV] = '{ 0,  1,  2,  3,  3,  1,  2,  0,  0};
  localparam int V_PIN[NV] = '{ 0,  1,  4,  0,  0,  3,  2,  0,  0};
  localparam int V_OBS[NV] = '{ 0,  5,  5, 15, 15, 15, 15,  0,  0};
  localparam int EXPC [NP] = '{9, 2, 5, 0, 7, 3};

  logic clk = 0, rst_n = 0, start = 0;
  logic [NP-1:0] in_mask = '0, out_mask = '0, pin_obs;
  logic [NP*4-1:0] exp_tab;
  logic tck, tms, tdi, m_tdo = 0;
  logic [NP-1:0] pin_drv, pin_drv_en;
  logic busy, done, fail;
  logic [1:0] err_code;
  logic [2:0] err_pin;
  logic [3:0] err_obs;
  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  walk1_pinmap_verifier i_walk1_pinmap_verifier (
    .clk(clk), .rst_n(rst_n), .start(start), .in_mask(in_mask), .out_mask(out_mask),
    .exp_tab(exp_tab), .tck(tck), .tms(tms), .tdi(tdi), .tdo(m_tdo),
    .pin_drv(pin_drv), .pin_drv_en(pin_drv_en), .pin_obs(pin_obs),
    .busy(busy), .done(done), .fail(fail), .err_code(err_code),
    .err_pin(err_pin), .err_obs(err_obs));

  // target model
  int ts = 0, m_len = 10, n_rise = 0, n_cap_sam = 0, n_cap_ext = 0, n_bad_edge = 0;
  int m_in[NP], m_out[NP];
  logic [3:0] m_ir = 4'hF, m_irsh = 4'h0;
  logic [31:0] breg = '0, upd = '0;

  function automatic int tap_next(int s, logic t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  always @(posedge tck) begin
    n_rise++;
    case (ts)
      0: m_ir = 4'hF;
      3: begin
        breg = '0;
        for (int p = 0; p < NP; p++)
          if (m_in[p] >= 0) breg[m_in[p]] = pin_drv_en[p] & pin_drv[p];
        if (m_ir == SAM) n_cap_sam++;
        if (m_ir == EXT) n_cap_ext++;
      end
      4: begin breg = breg >> 1; breg[m_len-1] = tdi; end
      8: upd = breg;
      10: m_irsh = 4'b0001;
      11: m_irsh = {tdi, m_irsh[3:1]};
      15: m_ir = m_irsh;
      default: ;
    endcase
    ts = tap_next(ts, tms);
  end

  always @(negedge tck) m_tdo <= (ts == 4) ? breg[0] : (ts == 11) ? m_irsh[0] : 1'b0;

  always_comb
    for (int p = 0; p < NP; p++)
      pin_obs[p] = (m_ir == EXT && m_out[p] >= 0) ? upd[m_out[p]] : 1'b0;

  always @(tms or tdi) if (tck) n_bad_edge++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_model(input int v, input int len);
    for (int p = 0; p < NP; p++) begin m_in[p] = EXPC[p]; m_out[p] = EXPC[p]; end
    m_len = len;
    case (v)
      1: begin m_in[1] = 5; m_in[2] = 2; end
      2: begin m_out[4] = 3; m_out[5] = 7; end
      3: m_in[3] = -1;
      4: m_out[2] = -1;
      default: ;
    endcase
  endtask

  task automatic run_once(output bit ok);
    n_rise = 0; n_cap_sam = 0; n_cap_ext = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    ok = 0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  initial begin
    #(200000*PERIOD);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ok;
    for (int p = 0; p < NP; p++) exp_tab[p*4 +: 4] = 4'(EXPC[p]);
    set_model(0, 10);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !tck && pin_drv_en == 0 && err_code == 0,
        "R1 reset state", {busy, done, fail, tck}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !tck, "R1 idle after reset", {busy, done, tck}, 0);

    for (int v = 0; v < NV; v++) begin
      in_mask = NP'(V_IN[v]); out_mask = NP'(V_OUT[v]);
      set_model(V_VAR[v], V_LEN[v]);
      run_once(ok);
      chk(ok, "R7/R8 run completes", ok, 1);
      chk(err_code == 2'(V_COD[v]), $sformatf("R4/R5/R6/R8 code v%0d", v), err_code, V_COD[v]);
      chk(fail == (V_COD[v] != 0), $sformatf("R7/R8 fail flag v%0d", v), fail, V_COD[v] != 0);
      if (V_COD[v] != 0) begin
        chk(err_pin == 3'(V_PIN[v]), $sformatf("R4/R6 err pin v%0d", v), err_pin, V_PIN[v]);
        chk(err_obs == 4'(V_OBS[v]), $sformatf("R4/R5/R6 err obs v%0d", v), err_obs, V_OBS[v]);
      end
      if (v == 0) begin
        chk(n_rise == 210, "R10 rising edges full pass", n_rise, 210);
        chk(n_cap_sam == 4, "R2 captures under sampling opcode", n_cap_sam, 4);
        chk(n_cap_ext == 4, "R2 captures under external-test opcode", n_cap_ext, 4);
      end
      if (v == 7) chk(n_rise == 26, "R9 empty masks edge count", n_rise, 26);
      if (v == 8) chk(n_cap_sam == 1, "R9 masked pins skipped", n_cap_sam, 1);
      if (v == 6) chk(n_cap_ext == 1, "R9 bidir pin in output pass", n_cap_ext, 1);
      if (v == 1) begin
        repeat (40) @(negedge clk);
        chk(done && fail && err_code == 2'd1 && err_pin == 3'd1 && err_obs == 4'd5 && !tck,
            "R7 results held", {err_code, err_pin}, {2'd1, 3'd1});
      end
    end

    chk(n_bad_edge == 0, "R10 tms/tdi stable while tck high", n_bad_edge, 0);

    in_mask = 6'h01; out_mask = 6'h00; set_model(0, 10);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (60) @(negedge clk);
    chk(pin_drv == 6'h01 && pin_drv_en == 6'h01, "R3 drive during first input scan",
        {pin_drv, pin_drv_en}, {6'h01, 6'h01});
    for (int c = 0; c < 2000 && !done; c++) @(negedge clk);
    chk(done && !fail, "R8 single pin pass", fail, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule